// File: doc/BRIEF.md
# Dual-mode capture/compare timer

This block is a counter of `CNT_W` bits (16 by default) that either runs as one wide timer or splits into two independent half-width timers, an upper half and a lower half. In timer mode the wide or upper counter advances on a clock-enable `tick`. In external counting mode it advances on rising edges of the input pin. An external pin can gate the wide or upper counter's tick. The same pin can capture the wide counter value on a chosen edge, optionally reloading the counter. Each counter reloads from its reload value when it wraps and raises sticky flags on wrap and on compare match. Two output pins toggle on those events.

Software reaches the block through a small register port. Writes take effect at the next clock edge. Reads are combinational. The registers are:

- Address 0, mode register: bit0 gate enable, bit1 split, bit2 run upper/wide, bit3 run lower, bit4 external counting, bit5 output A enable, bit6 polarity A, bits 8:7 capture edge select (00 none, 01 rising, 10 falling, 11 both), bit9 reload on capture, bit10 main interrupt enable.
- Address 1, status register: bit7 low interrupt enable, bit6 output B enable, bit5 polarity B, bit3 overflow, bit2 low overflow, bit1 capture/compare, bit0 low compare.
- Address 2: reload. Address 3: compare. Address 4: counter, writable. Address 5: capture, read-only.

In split mode the upper byte of the reload, compare and counter registers belongs to the upper timer, and the lower byte belongs to the lower timer.

Top module: `dualModeTimer`

## Requirements
- R1: After reset every register, the counter, the capture value, all flags, both output pins and both interrupt requests read zero.
- R2: With split=0 and run set, each tick adds one to the wide counter. A step from all-ones loads the reload value instead and sets the overflow flag (status bit3).
- R3: With split=1, the upper byte steps on ticks when run-upper is set, and the lower byte steps on ticks when run-lower is set. Each byte wraps independently to its own reload byte.
- R4: The low overflow flag (status bit2) sets when the lower byte wraps, and never in wide mode.
- R5: The capture/compare flag (status bit1) sets when a step lands on the compare value. The match uses the full width in wide mode and the upper byte in split mode. The low compare flag (status bit0) sets only in split mode, when the lower byte lands on the compare low byte.
- R6: With gate enable set, output A disabled and timer mode selected, the wide or upper counter steps only while the synchronized pin is high. The lower counter is never gated. Gating has no effect while output A is enabled.
- R7: With external counting (mode bit4) and output A disabled, the wide or upper counter steps once per rising pin edge, and ticks are ignored.
- R8: A pin edge matching the capture edge select copies the counter into the capture register and sets status bit1. With mode bit9 set, the same edge also loads the counter from reload.
- R9: With capture select 11, bit9 set and gate enable set, polarity A chooses an edge that captures without reloading: 0 skips reload on the falling edge, and 1 skips it on the rising edge.
- R10: Flags stay set until software writes 0 to them. A hardware set in the same cycle as a clearing write wins.
- R11: Outputs read 0 while disabled. On enable, each output loads its polarity bit. Output A toggles on wide/upper match or wrap. Output B follows the same events in wide mode and the lower timer's events in split mode.
- R12: Writing polarity B while output B is enabled leaves the output unchanged.
- R13: irqLow is the low interrupt enable ANDed with (low overflow OR low compare). irqMain is mode bit10 ANDed with (overflow OR capture/compare).
- R14: Status bits 15:8 and bit4 read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data for `addr` |
| tick | input | 1 | Count-clock enable |
| pinIn | input | 1 | External pin level, asynchronous |
| outA | output | 1 | Primary toggle output |
| outB | output | 1 | Secondary toggle output |
| irqMain | output | 1 | Wide/upper interrupt request |
| irqLow | output | 1 | Lower-half interrupt request |

## Verification
The hardest case to reach from the ports is the both-edge capture with one reload suppressed. Reaching it needs the pin configured as an input, capture and reload enabled on both edges, and the gate bit reinterpreted. The counter must also be frozen so that captured and reloaded values can be told apart. The stimulus stops all ticks and rewrites the counter between edges. It then drives each pin edge and holds it long enough for the synchronizer, once for each polarity. Wraps and compare hits in wide mode come from a seeded random tick pattern, with the counter started near all-ones and compare placed just past reload.

// File: rtl/dualTimerPkg.sv
package dualTimerPkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_MODE    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RELOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COMPARE = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_COUNT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CAPTURE = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic stepHi;
    logic stepLo;
    logic capture;
    logic capLoad;
    logic wrCount;
  } strobe_t;

  // datapath -> control events
  typedef struct packed {
    logic ovfHi;
    logic ovfLo;
    logic matchHi;
    logic matchLo;
  } event_t;
endpackage

// File: rtl/dualTimerPath.sv
module dualTimerPath
  import dualTimerPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic         split,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] reloadVal,
  input  logic [W-1:0] compareVal,
  output logic [W-1:0] count,
  output logic [W-1:0] captureVal,
  output event_t       evt
);
  localparam int H = W / 2;

  logic [W-1:0] nextCount, fullNext;
  logic [H-1:0] hiCur, loCur, hiNext, loNext;

  assign hiCur = count[W-1:H];
  assign loCur = count[H-1:0];

  always_comb begin
    fullNext = (&count) ? reloadVal : count + W'(1);
    hiNext   = (&hiCur) ? reloadVal[W-1:H] : hiCur + H'(1);
    loNext   = (&loCur) ? reloadVal[H-1:0] : loCur + H'(1);
    nextCount = count;
    evt = '0;
    if (stb.wrCount) begin
      nextCount = wrData;
    end else if (!split) begin
      if (stb.capLoad) begin
        nextCount = reloadVal;
      end else if (stb.stepHi) begin
        nextCount   = fullNext;
        evt.ovfHi   = &count;
        evt.matchHi = (fullNext == compareVal);
      end
    end else begin
      if (stb.capLoad) begin
        nextCount[W-1:H] = reloadVal[W-1:H];
      end else if (stb.stepHi) begin
        nextCount[W-1:H] = hiNext;
        evt.ovfHi        = &hiCur;
        evt.matchHi      = (hiNext == compareVal[W-1:H]);
      end
      if (stb.stepLo) begin
        nextCount[H-1:0] = loNext;
        evt.ovfLo        = &loCur;
        evt.matchLo      = (loNext == compareVal[H-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      captureVal <= '0;
    end else begin
      count <= nextCount;
      if (stb.capture) captureVal <= split ? {hiCur, H'(0)} : count;
    end
  end

  // R2: wide wrap loads reload value
  assert_reload_on_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!split && stb.stepHi && !stb.capLoad && !stb.wrCount && (&count))
      |=> (count == $past(reloadVal)));

  // R3: lower half only steps in split mode
  assert_low_step_split_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepLo |-> split);

  // R8: reload on capture
  assert_cap_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capLoad && !stb.wrCount && !split) |=> (count == $past(reloadVal)));
endmodule

// File: rtl/dualTimerCtrl.sv
module dualTimerCtrl
  import dualTimerPkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  input  logic          tick,
  input  logic          pinIn,
  input  logic [W-1:0]  count,
  input  logic [W-1:0]  captureVal,
  input  event_t        evt,
  output strobe_t       stb,
  output logic          split,
  output logic [W-1:0]  reloadVal,
  output logic [W-1:0]  compareVal,
  output logic          outA,
  output logic          outB,
  output logic          irqMain,
  output logic          irqLow
);
  localparam int MODE_W = 11;
  localparam int SYNC_N = 3;

  logic [MODE_W-1:0] modeQ;
  logic [W-1:0]      reloadQ, compareQ;
  logic              lowIntEn, outEnB, polB;
  logic [3:0]        flagsQ, flagsNext;
  logic              outAQ, outBQ;
  logic [SYNC_N-1:0] syncQ;

  logic gateEn, runHi, runLo, extCount, outEnA, polA, capReload, mainIntEn;
  logic [1:0] capSel;
  logic pinLvl, rise, fall, pinIsInput, bothEdge, gateActive, gateOpen, capEvt, skipReload;
  logic wrMode, wrStatus, toggleA, toggleB;

  assign gateEn    = modeQ[0];
  assign split     = modeQ[1];
  assign runHi     = modeQ[2];
  assign runLo     = modeQ[3];
  assign extCount  = modeQ[4];
  assign outEnA    = modeQ[5];
  assign polA      = modeQ[6];
  assign capSel    = modeQ[8:7];
  assign capReload = modeQ[9];
  assign mainIntEn = modeQ[10];

  assign wrMode   = wrEn && (addr == ADR_MODE);
  assign wrStatus = wrEn && (addr == ADR_STATUS);

  // pin synchronizer and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-2:0], pinIn};
  end
  assign pinLvl = syncQ[1];
  assign rise   = syncQ[1] & ~syncQ[2];
  assign fall   = ~syncQ[1] & syncQ[2];

  always_comb begin
    pinIsInput  = ~outEnA;
    bothEdge    = (capSel == 2'b11) && capReload;
    gateActive  = gateEn && pinIsInput && !extCount && !bothEdge;
    gateOpen    = !gateActive || pinLvl;
    capEvt      = pinIsInput && !extCount && ((capSel[0] && rise) || (capSel[1] && fall));
    skipReload  = bothEdge && gateEn && (polA ? rise : fall);
    stb.stepHi  = runHi && (extCount ? (pinIsInput && rise) : (tick && gateOpen));
    stb.stepLo  = split && runLo && tick;
    stb.capture = capEvt;
    stb.capLoad = capEvt && capReload && !skipReload;
    stb.wrCount = wrEn && (addr == ADR_COUNT);
  end

  always_comb begin
    flagsNext = flagsQ;
    if (wrStatus) flagsNext = wrData[3:0];
    flagsNext = flagsNext | {evt.ovfHi, evt.ovfLo, evt.matchHi | capEvt, evt.matchLo};
  end

  assign toggleA = evt.ovfHi | evt.matchHi;
  assign toggleB = split ? (evt.ovfLo | evt.matchLo) : toggleA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= '0;
      reloadQ  <= '0;
      compareQ <= '0;
      lowIntEn <= 1'b0;
      outEnB   <= 1'b0;
      polB     <= 1'b0;
      flagsQ   <= '0;
      outAQ    <= 1'b0;
      outBQ    <= 1'b0;
    end else begin
      flagsQ <= flagsNext;
      if (wrMode) modeQ <= wrData[MODE_W-1:0];
      if (wrEn && addr == ADR_RELOAD)  reloadQ  <= wrData;
      if (wrEn && addr == ADR_COMPARE) compareQ <= wrData;
      if (wrStatus) begin
        lowIntEn <= wrData[7];
        outEnB   <= wrData[6];
        polB     <= wrData[5];
      end
      if (wrMode && wrData[5] && !outEnA) outAQ <= wrData[6];
      else if (toggleA)                   outAQ <= ~outAQ;
      if (wrStatus && wrData[6] && !outEnB) outBQ <= wrData[5];
      else if (toggleB)                     outBQ <= ~outBQ;
    end
  end

  assign reloadVal  = reloadQ;
  assign compareVal = compareQ;
  assign outA       = outEnA & outAQ;
  assign outB       = outEnB & outBQ;
  assign irqMain    = mainIntEn & (flagsQ[3] | flagsQ[1]);
  assign irqLow     = lowIntEn & (flagsQ[2] | flagsQ[0]);

  always_comb begin
    case (addr)
      ADR_MODE:    rdData = W'(modeQ);
      ADR_STATUS:  rdData = W'({lowIntEn, outEnB, polB, 1'b0, flagsQ});
      ADR_RELOAD:  rdData = reloadQ;
      ADR_COMPARE: rdData = compareQ;
      ADR_COUNT:   rdData = count;
      ADR_CAPTURE: rdData = captureVal;
      default:     rdData = '0;
    endcase
  end

  // R2 / R10: wrap event always leaves overflow flag set
  assert_ovf_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovfHi |=> flagsQ[3]);

  // R4: lower wrap only reported in split mode
  assert_low_ovf_split_R4: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovfLo |-> split);

  // R12: enabled output B holds unless an event or a disable occurs
  assert_polb_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outEnB && !toggleB && !(wrStatus && !wrData[6])) |=> $stable(outB));
endmodule

// File: rtl/dualModeTimer.sv
module dualModeTimer
  import dualTimerPkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] rdData,
  input  logic          tick,
  input  logic          pinIn,
  output logic          outA,
  output logic          outB,
  output logic          irqMain,
  output logic          irqLow
);
  strobe_t       stb;
  event_t        evt;
  logic          split;
  logic [CW-1:0] reloadVal, compareVal, count, captureVal;

  dualTimerCtrl #(.W(CW), .AW(AW)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .pinIn(pinIn), .count(count),
    .captureVal(captureVal), .evt(evt), .stb(stb), .split(split),
    .reloadVal(reloadVal), .compareVal(compareVal), .outA(outA),
    .outB(outB), .irqMain(irqMain), .irqLow(irqLow)
  );

  dualTimerPath #(.W(CW)) path (
    .clk(clk), .rstN(rstN), .stb(stb), .split(split), .wrData(wrData),
    .reloadVal(reloadVal), .compareVal(compareVal), .count(count),
    .captureVal(captureVal), .evt(evt)
  );
endmodule

// File: tb/dualModeTimer_test.sv
`timescale 1ns/1ps
module dualModeTimer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        tick = 1'b0;
  logic        pinIn = 1'b0;
  logic        outA, outB, irqMain, irqLow;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  dualModeTimer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .pinIn(pinIn), .outA(outA), .outB(outB),
    .irqMain(irqMain), .irqLow(irqLow)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] rd(input logic [2:0] a);
    addr = a;
    return 16'h0;
  endfunction

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setPin(input logic v);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkReg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    readReg(a, d);
    check(req, d, exp);
  endtask

  // reference step for the wide counter
  function automatic logic [15:0] wideStep(input logic [15:0] c, input logic [15:0] rel);
    return (c == 16'hFFFF) ? rel : c + 16'd1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] m, rel, cmp, d;
    logic ovfE, ccE;
    void'($urandom(32'd20240611));
    void'(rd(3'd0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkReg("R1 mode", 3'd0, 16'h0000);
    checkReg("R1 status", 3'd1, 16'h0000);
    checkReg("R1 count", 3'd4, 16'h0000);
    checkReg("R1 capture", 3'd5, 16'h0000);
    check("R1 outputs/irqs", {12'h0, outA, outB, irqMain, irqLow}, 16'h0);

    // R2 R5 R11: wide compare and wrap
    wr(3'd2, 16'hFFF0);
    wr(3'd3, 16'h0010);
    wr(3'd4, 16'h000E);
    wr(3'd0, 16'h0064);
    check("R11 outA loads polA", {15'h0, outA}, 16'h1);
    ticks(2);
    checkReg("R2 count steps", 3'd4, 16'h0010);
    checkReg("R5 cc flag wide", 3'd1, 16'h0002);
    check("R11 outA toggles on match", {15'h0, outA}, 16'h0);
    wr(3'd4, 16'hFFFE);
    ticks(2);
    checkReg("R2 wrap to reload", 3'd4, 16'hFFF0);
    checkReg("R2 R4 ovf set, no low ovf in wide", 3'd1, 16'h000A);
    check("R11 outA toggles on wrap", {15'h0, outA}, 16'h1);
    check("R13 irqMain masked", {15'h0, irqMain}, 16'h0);
    wr(3'd0, 16'h0464);
    check("R13 irqMain enabled", {15'h0, irqMain}, 16'h1);
    check("R11 no reload on re-enable", {15'h0, outA}, 16'h1);
    wr(3'd1, 16'h0000);
    checkReg("R10 write 0 clears", 3'd1, 16'h0000);
    wr(3'd1, 16'hFF10);
    checkReg("R14 reserved bits read zero", 3'd1, 16'h0000);

    // R3 R4 R5 R11 R13: split mode
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h1020);
    wr(3'd3, 16'h1120);
    wr(3'd4, 16'hFFFE);
    wr(3'd1, 16'h00C0);
    check("R11 outB loads polB 0", {15'h0, outB}, 16'h0);
    wr(3'd0, 16'h006E);
    ticks(1);
    checkReg("R3 upper wraps, lower steps", 3'd4, 16'h10FF);
    checkReg("R3 only ovf after first tick", 3'd1, 16'h00C8);
    check("R11 outA after upper wrap", {15'h0, outA}, 16'h0);
    ticks(1);
    checkReg("R3 lower wraps to reload byte", 3'd4, 16'h1120);
    checkReg("R4 R5 all split flags", 3'd1, 16'h00CF);
    check("R11 outB follows lower", {15'h0, outB}, 16'h1);
    check("R11 outA back after match", {15'h0, outA}, 16'h1);
    check("R13 irqLow", {15'h0, irqLow}, 16'h1);
    wr(3'd1, 16'h00C0);
    check("R12 polB write ignored while enabled", {15'h0, outB}, 16'h1);
    check("R13 irqLow cleared", {15'h0, irqLow}, 16'h0);
    wr(3'd1, 16'h0080);
    check("R11 outB disabled reads 0", {15'h0, outB}, 16'h0);
    wr(3'd1, 16'h00E0);
    check("R11 outB loads polB 1", {15'h0, outB}, 16'h1);

    // R6 gating
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0000);
    setPin(1'b0);
    wr(3'd0, 16'h0005);
    ticks(5);
    checkReg("R6 gated while pin low", 3'd4, 16'h0000);
    setPin(1'b1);
    ticks(5);
    checkReg("R6 counts while pin high", 3'd4, 16'h0005);
    setPin(1'b0);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h000F);
    ticks(3);
    checkReg("R6 lower never gated", 3'd4, 16'h0003);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0025);
    ticks(3);
    checkReg("R6 no gating with output A on", 3'd4, 16'h0003);

    // R7 external counting
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0014);
    ticks(3);
    checkReg("R7 ticks ignored", 3'd4, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      setPin(1'b1);
      setPin(1'b0);
    end
    checkReg("R7 one step per rising edge", 3'd4, 16'h0003);

    // R8 capture
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h1234);
    wr(3'd2, 16'h0055);
    wr(3'd0, 16'h0080);
    setPin(1'b1);
    checkReg("R8 capture value", 3'd5, 16'h1234);
    checkReg("R8 no reload without bit9", 3'd4, 16'h1234);
    checkReg("R8 capture sets cc flag", 3'd1, 16'h0002);
    wr(3'd0, 16'h0280);
    setPin(1'b0);
    wr(3'd4, 16'h3333);
    setPin(1'b1);
    checkReg("R8 capture before reload", 3'd5, 16'h3333);
    checkReg("R8 reload on capture", 3'd4, 16'h0055);

    // R9 both-edge with skipped reload
    wr(3'd0, 16'h0381);
    wr(3'd4, 16'h1111);
    setPin(1'b0);
    checkReg("R9 falling captures", 3'd5, 16'h1111);
    checkReg("R9 pol0 skips falling reload", 3'd4, 16'h1111);
    wr(3'd4, 16'h2222);
    setPin(1'b1);
    checkReg("R9 rising captures", 3'd5, 16'h2222);
    checkReg("R9 pol0 reloads on rising", 3'd4, 16'h0055);
    wr(3'd0, 16'h03C1);
    wr(3'd4, 16'h4444);
    setPin(1'b0);
    checkReg("R9 pol1 reloads on falling", 3'd4, 16'h0055);
    wr(3'd4, 16'h6666);
    setPin(1'b1);
    checkReg("R9 pol1 skips rising reload", 3'd4, 16'h6666);
    checkReg("R9 pol1 rising captures", 3'd5, 16'h6666);

    // R2 R5 R10 random ticks in wide mode
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    rel = 16'hFFFF - 16'($urandom % 100);
    cmp = rel + 16'($urandom % 50);
    m = 16'hFFFF - 16'($urandom % 64);
    wr(3'd2, rel);
    wr(3'd3, cmp);
    wr(3'd4, m);
    wr(3'd0, 16'h0004);
    ovfE = 1'b0; ccE = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic t;
      t = 1'($urandom % 2);
      tick = t;
      if (t) begin
        if (m == 16'hFFFF) ovfE = 1'b1;
        m = wideStep(m, rel);
        if (m == cmp) ccE = 1'b1;
      end
      @(negedge clk);
      readReg(3'd4, d);
      check("R2 random count", d, m);
    end
    tick = 1'b0;
    readReg(3'd1, d);
    check("R5 R10 random flags", {14'h0, d[3], d[1]}, {14'h0, ovfE, ccE});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule